// File: doc/BRIEF.md
# Read-Only Miss-Stall Cluster Cache

This block is a small private data cache for a single compute cluster. Its contents are never written by the cluster. They change in only two ways: an explicit load command delivers a line (address plus data word) from the stream buffer, and an explicit invalidate command empties every line at once. No coherence logic exists between clusters or between nodes. Software and the controller decide when loads and invalidates happen.

When a cluster read misses, the cache raises a miss flag and exposes the address it needs. An external controller then stalls every cluster and supplies that word through the same fill port. The word may come from another cluster's cache or from memory. To find it in a peer, the controller searches the other caches in parallel through a separate probe port. The probe port is a combinational lookup that does not disturb the read port or the stall state. When the matching fill arrives, the cache completes the pending read with the filled word on the next cycle and resumes. Replacement is least-recently-used across the fully associative ways, tracked with per-way age counters.

Top module: `cluster_ro_cache`

## Requirements
- R1: While reset is held low at a clock edge, the next cycle shows `miss` low and `rd_valid` low, and no address hits on the probe port.
- R2: When not stalled, a read request to a resident address drives `rd_valid` high with the stored word on `rd_data` in the cycle after the request. `miss` stays low.
- R3: When not stalled, a read request to a non-resident address raises `miss` in the following cycle with `miss_addr` equal to the requested address, and `rd_valid` stays low.
- R4: While `miss` is high, `miss` and `miss_addr` hold and `rd_valid` stays low. Read requests are ignored. This continues until a fill whose address equals `miss_addr` arrives without an invalidate in the same cycle.
- R5: In the cycle after such a matching fill, `miss` is low, `rd_valid` is high and `rd_data` equals that fill's data. The address then becomes resident unless it already was.
- R6: Lines are read-only. A fill to an already resident address leaves the stored word unchanged.
- R7: A fill to a non-resident address installs the line whether or not a miss is pending, and a fill needs no read request.
- R8: An invalidate empties every line in one cycle. A fill in the same cycle is discarded entirely, including as a miss completion.
- R9: An install goes to the lowest-numbered empty way if there is one, otherwise to the least recently used way. Recency is refreshed by read hits and by installs. An install takes precedence over a read hit in the same cycle. Probes and ignored fills do not change recency.
- R10: `probe_hit`/`probe_data` report combinationally whether `probe_addr` is resident and its word, independent of read traffic and stall state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_req | input | 1 | Cluster read request |
| rd_addr | input | ADDR_W | Cluster read address |
| rd_valid | output | 1 | Read completed this cycle |
| rd_data | output | DATA_W | Read result |
| miss | output | 1 | Miss pending, clusters must stall |
| miss_addr | output | ADDR_W | Address needed to resolve the miss |
| fill_valid | input | 1 | Load command / miss fill |
| fill_addr | input | ADDR_W | Fill address |
| fill_data | input | DATA_W | Fill word |
| inval | input | 1 | Empty all lines |
| probe_addr | input | ADDR_W | Peer search address |
| probe_hit | output | 1 | Probe address resident |
| probe_data | output | DATA_W | Word at probe address |

## Verification
The bench builds the cache with four ways, 32-bit words and an 8-bit address. Its stimulus draws addresses from only eight values, twice the way count. Evictions, refills of just-evicted lines, hits during a pending miss and fills of already-resident lines therefore occur constantly. The age-counter ordering is exercised through every permutation that matters for victim choice. The bench's reference model keeps recency as an ordered list, so a wrong victim shows up quickly as a differing hit or miss.

// File: rtl/cc_pkg.sv
// Shared types for the read-only miss-stall cluster cache.
package cc_pkg;
    // Control state: running normally, or stalled awaiting a fill.
    typedef enum logic [0:0] {
        ST_RUN   = 1'b0,
        ST_STALL = 1'b1
    } cc_state_e;
endpackage

// File: rtl/cc_store.sv
// Line storage with three associative lookups: the cluster read port,
// the peer probe port and the fill port (to detect already-resident lines).
// Assumes at most one way holds any address (installs skip resident ones).
module cc_store #(
    parameter int NWAYS  = 4,
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    localparam int WAY_W = $clog2(NWAYS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              wr_en,
    input  logic [WAY_W-1:0]  wr_way,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] lk_addr,
    output logic              lk_hit,
    output logic [WAY_W-1:0]  lk_way,
    output logic [DATA_W-1:0] lk_data,
    input  logic [ADDR_W-1:0] pr_addr,
    output logic              pr_hit,
    output logic [DATA_W-1:0] pr_data,
    input  logic [ADDR_W-1:0] fl_addr,
    output logic              fl_hit,
    output logic [NWAYS-1:0]  valid_vec
);
    logic [NWAYS-1:0]  vld;
    logic [ADDR_W-1:0] tag_q [NWAYS];
    logic [DATA_W-1:0] dat_q [NWAYS];
    logic [NWAYS-1:0]  m_lk, m_pr, m_fl;

    // Valid bits: cleared by reset or invalidate, set by an install.
    always_ff @(posedge clk) begin
        for (int i = 0; i < NWAYS; i++) begin
            if (!rst_n || clr)
                vld[i] <= 1'b0;
            else if (wr_en && wr_way == WAY_W'(i))
                vld[i] <= 1'b1;
        end
    end

    // Tag and data payload: written only when a line is installed.
    always_ff @(posedge clk) begin
        for (int i = 0; i < NWAYS; i++) begin
            if (wr_en && wr_way == WAY_W'(i)) begin
                tag_q[i] <= wr_addr;
                dat_q[i] <= wr_data;
            end
        end
    end

    // Per-way comparators for the three lookup addresses.
    for (genvar w = 0; w < NWAYS; w++) begin : g_cmp
        assign m_lk[w] = vld[w] && (tag_q[w] == lk_addr);
        assign m_pr[w] = vld[w] && (tag_q[w] == pr_addr);
        assign m_fl[w] = vld[w] && (tag_q[w] == fl_addr);
    end

    // Encode read-port match into way index and data.
    always_comb begin
        lk_way  = '0;
        lk_data = '0;
        for (int i = 0; i < NWAYS; i++) begin
            if (m_lk[i]) begin
                lk_way  = WAY_W'(i);
                lk_data = dat_q[i];
            end
        end
    end

    // Select probe-port data.
    always_comb begin
        pr_data = '0;
        for (int i = 0; i < NWAYS; i++) begin
            if (m_pr[i]) pr_data = dat_q[i];
        end
    end

    assign lk_hit    = |m_lk;
    assign pr_hit    = |m_pr;
    assign fl_hit    = |m_fl;
    assign valid_vec = vld;
endmodule

// File: rtl/cc_lru.sv
// Age-counter LRU tracker. Ages form a permutation of 0..NWAYS-1; the
// touched way becomes 0 and younger ways age by one. Victim is the lowest
// empty way, else the way with the maximum age. Assumes NWAYS is a power of two.
module cc_lru #(
    parameter int NWAYS = 4,
    localparam int WAY_W = $clog2(NWAYS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             touch,
    input  logic [WAY_W-1:0] touch_way,
    input  logic [NWAYS-1:0] valid_vec,
    output logic [WAY_W-1:0] victim
);
    logic [WAY_W-1:0] age [NWAYS];
    logic             found;

    // Age update: reset to way index, refresh on touch.
    always_ff @(posedge clk) begin
        for (int i = 0; i < NWAYS; i++) begin
            if (!rst_n)
                age[i] <= WAY_W'(i);
            else if (touch) begin
                if (touch_way == WAY_W'(i))
                    age[i] <= '0;
                else if (age[i] < age[touch_way])
                    age[i] <= age[i] + 1'b1;
            end
        end
    end

    // Victim choice: first empty way, else the oldest way.
    always_comb begin
        victim = '0;
        found  = 1'b0;
        for (int i = 0; i < NWAYS; i++) begin
            if (!found && !valid_vec[i]) begin
                victim = WAY_W'(i);
                found  = 1'b1;
            end
        end
        if (!found) begin
            for (int i = 0; i < NWAYS; i++) begin
                if (age[i] == WAY_W'(NWAYS - 1)) victim = WAY_W'(i);
            end
        end
    end
endmodule

// File: rtl/cluster_ro_cache.sv
// Read-only, fully associative cluster cache with miss-stall handling.
// Reads hit with one cycle of latency; a miss enters a stall that exposes
// the missing address until a matching fill arrives, after which the read
// completes with the fill word. Fills install only non-resident lines.
module cluster_ro_cache #(
    parameter int NWAYS  = 4,
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_req,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              miss,
    output logic [ADDR_W-1:0] miss_addr,
    input  logic              fill_valid,
    input  logic [ADDR_W-1:0] fill_addr,
    input  logic [DATA_W-1:0] fill_data,
    input  logic              inval,
    input  logic [ADDR_W-1:0] probe_addr,
    output logic              probe_hit,
    output logic [DATA_W-1:0] probe_data
);
    import cc_pkg::*;
    localparam int WAY_W = $clog2(NWAYS);

    cc_state_e         state_q;
    logic [ADDR_W-1:0] miss_addr_q;
    logic              rdv_q;
    logic [DATA_W-1:0] rdata_q;

    logic              lk_hit, fl_hit;
    logic [WAY_W-1:0]  lk_way, victim, touch_way;
    logic [DATA_W-1:0] lk_data;
    logic [NWAYS-1:0]  valid_vec;
    logic              running, fill_ok, hit_now, miss_now, replay, install, touch;

    assign running   = (state_q == ST_RUN);
    assign fill_ok   = fill_valid && !inval;
    assign hit_now   = running && rd_req && lk_hit;
    assign miss_now  = running && rd_req && !lk_hit;
    assign replay    = !running && fill_ok && (fill_addr == miss_addr_q);
    assign install   = fill_ok && !fl_hit;
    assign touch     = install || hit_now;
    assign touch_way = install ? victim : lk_way;

    cc_store #(.NWAYS(NWAYS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (inval),
        .wr_en     (install),
        .wr_way    (victim),
        .wr_addr   (fill_addr),
        .wr_data   (fill_data),
        .lk_addr   (rd_addr),
        .lk_hit    (lk_hit),
        .lk_way    (lk_way),
        .lk_data   (lk_data),
        .pr_addr   (probe_addr),
        .pr_hit    (probe_hit),
        .pr_data   (probe_data),
        .fl_addr   (fill_addr),
        .fl_hit    (fl_hit),
        .valid_vec (valid_vec)
    );

    cc_lru #(.NWAYS(NWAYS)) u_lru (
        .clk       (clk),
        .rst_n     (rst_n),
        .touch     (touch),
        .touch_way (touch_way),
        .valid_vec (valid_vec),
        .victim    (victim)
    );

    // Stall control: enter on a miss, leave on the matching fill.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_RUN;
            miss_addr_q <= '0;
        end else if (miss_now) begin
            state_q     <= ST_STALL;
            miss_addr_q <= rd_addr;
        end else if (replay) begin
            state_q     <= ST_RUN;
        end
    end

    // Read result register: hit data or replayed fill word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdv_q   <= 1'b0;
            rdata_q <= '0;
        end else begin
            rdv_q <= hit_now || replay;
            if (hit_now)
                rdata_q <= lk_data;
            else if (replay)
                rdata_q <= fill_data;
        end
    end

    assign rd_valid  = rdv_q;
    assign rd_data   = rdata_q;
    assign miss      = (state_q == ST_STALL);
    assign miss_addr = miss_addr_q;
endmodule

// File: rtl/cluster_ro_cache_chk.sv
// Port-level protocol checker for cluster_ro_cache, attached by bind.
module cluster_ro_cache_chk #(
    parameter int NWAYS  = 4,
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_req,
    input logic [ADDR_W-1:0] rd_addr,
    input logic              rd_valid,
    input logic [DATA_W-1:0] rd_data,
    input logic              miss,
    input logic [ADDR_W-1:0] miss_addr,
    input logic              fill_valid,
    input logic [ADDR_W-1:0] fill_addr,
    input logic [DATA_W-1:0] fill_data,
    input logic              inval,
    input logic [ADDR_W-1:0] probe_addr,
    input logic              probe_hit,
    input logic [DATA_W-1:0] probe_data
);
    logic match_fill;
    assign match_fill = fill_valid && !inval && (fill_addr == miss_addr);

    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> !miss && !rd_valid && !probe_hit);

    assert_read_outcome_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !miss && rd_req |=> (rd_valid != miss));

    assert_miss_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !miss && rd_req |=> !miss || (miss_addr == $past(rd_addr)));

    assert_stall_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        miss && !match_fill |=> miss && $stable(miss_addr) && !rd_valid);

    assert_replay_R5: assert property (@(posedge clk) disable iff (!rst_n)
        miss && match_fill |=> !miss && rd_valid && (rd_data == $past(fill_data)));

    assert_inval_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
        inval |=> !probe_hit);
endmodule

bind cluster_ro_cache cluster_ro_cache_chk #(
    .NWAYS(NWAYS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (.*);

// File: tb/test_cluster_ro_cache.sv
`timescale 1ns/1ps
// Bench: behavioural reference model (ordered recency list) compared every cycle.
module test_cluster_ro_cache;
    localparam int NW = 4;
    localparam int AW = 8;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rd_req = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic          rd_valid, miss, probe_hit;
    logic [DW-1:0] rd_data, probe_data;
    logic [AW-1:0] miss_addr;
    logic          fill_valid = 1'b0;
    logic [AW-1:0] fill_addr = '0;
    logic [DW-1:0] fill_data = '0;
    logic          inval = 1'b0;
    logic [AW-1:0] probe_addr = '0;

    int tests = 0;
    int fails = 0;
    bit done = 0;

    // Reference model state
    bit          mv [NW];
    logic [AW-1:0] ma [NW];
    logic [DW-1:0] md [NW];
    int          ord [$];
    bit          mstall;
    logic [AW-1:0] mmaddr;
    bit          erdv;
    logic [DW-1:0] erdata;

    always #4 clk = ~clk;

    cluster_ro_cache #(.NWAYS(NW), .ADDR_W(AW), .DATA_W(DW)) i_cluster_ro_cache (
        .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_addr(rd_addr),
        .rd_valid(rd_valid), .rd_data(rd_data), .miss(miss), .miss_addr(miss_addr),
        .fill_valid(fill_valid), .fill_addr(fill_addr), .fill_data(fill_data),
        .inval(inval), .probe_addr(probe_addr), .probe_hit(probe_hit),
        .probe_data(probe_data)
    );

    task automatic chk(string tag, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic int find(logic [AW-1:0] a);
        for (int i = 0; i < NW; i++) if (mv[i] && ma[i] == a) return i;
        return -1;
    endfunction

    task automatic make_mru(int w);
        for (int i = 0; i < ord.size(); i++) if (ord[i] == w) begin ord.delete(i); break; end
        ord.push_front(w);
    endtask

    // Model update for one clock edge using the inputs held across it.
    task automatic model_edge();
        int h, fh, v;
        bit fok, hitn, missn, rep;
        if (!rst_n) begin
            for (int i = 0; i < NW; i++) mv[i] = 0;
            ord = {0, 1, 2, 3};
            mstall = 0; erdv = 0;
            return;
        end
        h     = find(rd_addr);
        fh    = find(fill_addr);
        fok   = fill_valid && !inval;
        hitn  = !mstall && rd_req && h >= 0;
        missn = !mstall && rd_req && h < 0;
        rep   = mstall && fok && fill_addr == mmaddr;
        erdv  = hitn || rep;
        if (hitn) erdata = md[h];
        else if (rep) erdata = fill_data;
        if (missn) begin mstall = 1; mmaddr = rd_addr; end
        else if (rep) mstall = 0;
        if (fok && fh < 0) begin
            v = -1;
            for (int i = 0; i < NW; i++) if (v < 0 && !mv[i]) v = i;
            if (v < 0) v = ord[$];
            ma[v] = fill_addr; md[v] = fill_data; mv[v] = 1;
            make_mru(v);
        end else if (hitn) make_mru(h);
        if (inval) for (int i = 0; i < NW; i++) mv[i] = 0;
    endtask

    // One cycle: drive at falling edge, check probe, clock, check registered outputs.
    task automatic step(string tag, bit rq, logic [AW-1:0] ra, bit fv,
                        logic [AW-1:0] fa, logic [DW-1:0] fd, bit iv, logic [AW-1:0] pa);
        int p;
        rd_req = rq; rd_addr = ra; fill_valid = fv; fill_addr = fa;
        fill_data = fd; inval = iv; probe_addr = pa;
        #1;
        if (rst_n) begin
            p = find(pa);
            chk("R10", "probe_hit", 32'(probe_hit), 32'(p >= 0));
            if (p >= 0) chk("R10", "probe_data", probe_data, md[p]);
        end
        @(posedge clk);
        model_edge();
        @(negedge clk);
        chk(tag, "rd_valid", 32'(rd_valid), 32'(erdv));
        if (erdv) chk(tag, "rd_data", rd_data, erdata);
        chk(tag, "miss", 32'(miss), 32'(mstall));
        if (mstall) chk(tag, "miss_addr", 32'(miss_addr), 32'(mmaddr));
    endtask

    task automatic idle(string tag, logic [AW-1:0] pa);
        step(tag, 0, 0, 0, 0, 0, 0, pa);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        // R1: reset state
        idle("R1", 8'h10);
        idle("R1", 8'h10);
        #1; chk("R1", "probe_hit", 32'(probe_hit), 0);
        rst_n = 1'b1;
        // R7: explicit loads without reads
        step("R7", 0, 0, 1, 8'h10, 32'hA0, 0, 8'h10);
        step("R7", 0, 0, 1, 8'h11, 32'hA1, 0, 8'h10);
        step("R7", 0, 0, 1, 8'h12, 32'hA2, 0, 8'h11);
        step("R7", 0, 0, 1, 8'h13, 32'hA3, 0, 8'h12);
        idle("R10", 8'h13);
        idle("R10", 8'h55);
        // R2: hits
        step("R2", 1, 8'h12, 0, 0, 0, 0, 8'h10);
        step("R2", 1, 8'h10, 0, 0, 0, 0, 8'h10);
        step("R2", 1, 8'h13, 0, 0, 0, 0, 8'h10);
        // R6: reload of a resident address is dropped
        step("R6", 0, 0, 1, 8'h12, 32'hFFFF, 0, 8'h12);
        step("R6", 1, 8'h12, 0, 0, 0, 0, 8'h12);
        // R3: miss, R4: hold, ignored reads, unrelated fill, blocked fill
        step("R3", 1, 8'h20, 0, 0, 0, 0, 8'h20);
        step("R4", 1, 8'h10, 0, 0, 0, 0, 8'h20);
        step("R4", 0, 0, 1, 8'h30, 32'hB0, 0, 8'h30);
        step("R8", 0, 0, 1, 8'h20, 32'hDEAD, 1, 8'h20);
        step("R4", 1, 8'h11, 0, 0, 0, 0, 8'h20);
        // R5: matching fill completes the read
        step("R5", 1, 8'h11, 1, 8'h20, 32'hC20, 0, 8'h20);
        idle("R5", 8'h20);
        // R9: LRU victim selection, install beats hit
        step("R9", 0, 0, 1, 8'h40, 32'h40, 0, 8'h40);
        step("R9", 0, 0, 1, 8'h41, 32'h41, 0, 8'h41);
        step("R9", 0, 0, 1, 8'h42, 32'h42, 0, 8'h42);
        step("R9", 1, 8'h40, 0, 0, 0, 0, 8'h41);
        step("R9", 1, 8'h41, 1, 8'h43, 32'h43, 0, 8'h40);
        step("R9", 0, 0, 1, 8'h44, 32'h44, 0, 8'h20);
        step("R9", 1, 8'h42, 0, 0, 0, 0, 8'h42);
        step("R9", 1, 8'h41, 0, 0, 0, 0, 8'h41);
        // R8: invalidate and same-cycle fill
        step("R8", 0, 0, 0, 0, 0, 1, 8'h40);
        idle("R8", 8'h44);
        step("R8", 0, 0, 1, 8'h50, 32'h50, 1, 8'h50);
        idle("R8", 8'h50);
        step("R8", 1, 8'h50, 0, 0, 0, 0, 8'h50);
        step("R5", 0, 0, 1, 8'h50, 32'h5050, 0, 8'h50);
        // Mixed traffic over a narrow address range
        for (int n = 0; n < 3000; n++) begin
            bit rq, fv, iv;
            logic [AW-1:0] fa;
            rq = ($urandom_range(0, 1) == 1);
            fv = ($urandom_range(0, 4) == 0);
            fa = AW'($urandom_range(0, 7));
            if (mstall && $urandom_range(0, 2) == 0) begin fv = 1; fa = mmaddr; end
            iv = ($urandom_range(0, 49) == 0);
            step("R9", rq, AW'($urandom_range(0, 7)), fv, fa, $urandom, iv,
                 AW'($urandom_range(0, 7)));
        end
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule